// File: doc/BRIEF.md
# Self-Complementing ECC Key Array Controller

This block guards a small key memory whose words must survive long storage without silent corruption or imprinting of stored values in the cells. Each stored element is 73 bits wide. It holds 64 data bits, 8 SEC-DED check bits and one complement indicator. The check bits are computed over the data, the indicator and the parity of the element address. A word that is read back from the wrong location therefore shows up as a code error.

A host issues single-cycle read or write requests and receives a registered response two cycles later. The response carries the data, which is always corrected and brought back to true polarity, together with a corrected or uncorrectable flag. A background sequencer waits a programmable number of cycles and then walks every element once. At each element it reads the word, corrects it, inverts it, toggles its indicator and writes it back. This scrubs single-bit errors and flips the polarity of the stored array. The walk only uses cycles in which the host is silent, and it continues from the element where it stopped.

A counter tracks corrected errors over a fixed window of cycles. When that count exceeds a limit, the block enters a sticky fault state and refuses all host traffic until reset. A write-side mask lets test code flip chosen stored bits so that the error paths can be exercised.

Top module: `key_array_ctrl`

## Requirements
- R1: A stored element is laid out as bits [63:0] data, [71:64] check bits and [72] complement indicator. A host write stores the data with the indicator clear, then XORs the word with `req_inj` before storing it. A read of an untouched element returns the written data with both flags low.
- R2: Every request is answered by `rsp_valid` high for exactly one cycle, in the second cycle after the cycle in which `req` was high. `rsp_err` and `rsp_corr` are low whenever `rsp_valid` is low. A read issued right after a write to the same address returns the new data.
- R3: A read of an element with any single flipped data or check bit returns the true data, with `rsp_corr`=1 and `rsp_err`=0.
- R4: A read of an element with two flipped bits returns `rsp_err`=1, `rsp_corr`=0 and `rsp_rdata`=0.
- R5: The code also covers the complement indicator. A single flip of bit 72 is corrected, and the read still returns the true data with `rsp_corr`=1.
- R6: PERIOD cycles after reset, or after the end of the previous walk, a walk visits addresses 0 to DEPTH-1. It writes each element back inverted with its indicator toggled, and pulses `pass_done` for one cycle after the last write-back. Host reads return true data before and after a walk.
- R7: The walk writes back the corrected word, so a single-bit error is gone after a walk and later reads show `rsp_corr`=0. An element with an uncorrectable error is left unchanged.
- R8: Host requests take precedence over the walk, and the walk advances only in cycles without `req`. Host reads and writes interleaved with a walk return correct data.
- R9: `fault` rises when a corrected event pushes the window's count above ERR_LIMIT. Corrected events come from host reads and from walk reads. `fault` stays high until reset.
- R10: While `fault` is high, every request is answered with `rsp_err`=1, `rsp_corr`=0 and `rsp_rdata`=0.
- R11: During reset, `rsp_valid`, `rsp_err`, `rsp_corr`, `fault` and `pass_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(DEPTH) | Element address |
| req_wdata | input | 64 | Write data |
| req_inj | input | 73 | Bit-flip mask applied to the stored word on writes |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Corrected, true-polarity read data |
| rsp_err | output | 1 | Uncorrectable error or fenced access |
| rsp_corr | output | 1 | A single-bit error was corrected |
| fault | output | 1 | Sticky failure state |
| pass_done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
Two functions can land in the same cycle. One is the walk's write-back of an element, the other is a host access that reads or rewrites that same element. The read port then returns the pre-write word, so the design must forward the new word. To provoke this, the bench keeps the host busy two cycles out of three across the whole walk, cycling over clean addresses, so that walk slots fall right beside host accesses to neighbouring and identical elements. Every response is judged against the written pattern. After the walk, the scrubbed elements must read clean and the double-error element must still be flagged.

// File: rtl/kac_pkg.sv
package kac_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W  = 64;
  localparam int MSG_W   = DATA_W + 2;      // data, indicator, address parity
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int WORD_W  = DATA_W + CHK_W + 1;

  // Hamming position of message bit k: k-th integer >= 3 that is not a power of two
  function automatic logic [HAM_W-1:0] code_pos(input int k);
    int cnt;
    logic [HAM_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k) res = HAM_W'(p);
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [HAM_W-1:0] ham_syn(input logic [MSG_W-1:0] m);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int k = 0; k < MSG_W; k++)
      if (m[k]) h ^= code_pos(k);
    return h;
  endfunction
endpackage

// File: rtl/kac_ecc_enc.sv
module kac_ecc_enc
  import kac_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic              comp,
  input  logic              apar,
  output logic [WORD_W-1:0] word
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [MSG_W-1:0] msg;
  logic [HAM_W-1:0] ham;

  always_comb begin
    msg  = {apar, comp, data};
    ham  = ham_syn(msg);
    word = {comp, (^msg) ^ (^ham), ham, data};
  end
endmodule

// File: rtl/kac_ecc_dec.sv
module kac_ecc_dec
  import kac_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              apar,
  output logic [DATA_W-1:0] data,
  output logic              comp,
  output logic              corr,
  output logic              unc
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [MSG_W-1:0] msg;
  logic [MSG_W-2:0] fixed;
  logic [HAM_W-1:0] syn;
  logic             par, hit, pow2;

  always_comb begin
    msg   = {apar, word[WORD_W-1], word[DATA_W-1:0]};
    syn   = ham_syn(msg) ^ word[DATA_W+HAM_W-1:DATA_W];
    par   = (^msg) ^ (^word[DATA_W+CHK_W-1:DATA_W]);
    fixed = msg[MSG_W-2:0];
    hit   = 1'b0;
    // address parity is never corrected: a hit there means a wrong location
    for (int k = 0; k < MSG_W - 1; k++) begin
      if (par && (syn == code_pos(k))) begin
        fixed[k] = ~fixed[k];
        hit      = 1'b1;
      end
    end
    pow2 = ((syn & (syn - 1'b1)) == '0);
    corr = par && (hit || pow2);
    unc  = (par && !corr) || (!par && (syn != '0));
    data = fixed[DATA_W-1:0];
    comp = fixed[DATA_W];
  end
endmodule

// File: rtl/kac_walker.sv
module kac_walker #(
  parameter int DEPTH  = 64,
  parameter int PERIOD = 1_000_000,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  output logic          active,
  output logic [AW-1:0] addr,
  output logic          last
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] wait_cnt;

  assign last = (addr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
      active   <= 1'b0;
      addr     <= '0;
    end else if (!active) begin
      if (wait_cnt == CW'(PERIOD - 1)) begin
        wait_cnt <= '0;
        active   <= 1'b1;
        addr     <= '0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end else if (grant) begin
      if (last) active <= 1'b0;
      else      addr   <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/key_array_ctrl.sv
module key_array_ctrl
  import kac_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int PERIOD    = 1_000_000,
  parameter int ERR_LIMIT = 15,
  parameter int WINDOW    = 1 << 22,
  localparam int AW  = $clog2(DEPTH),
  localparam int WCW = $clog2(WINDOW),
  localparam int ECW = $clog2(ERR_LIMIT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] req_inj,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_corr,
  output logic              fault,
  output logic              pass_done
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              walk_active, walk_last, walk_grant;
  logic [AW-1:0]     walk_addr, issue_addr;
  logic              issue_v;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q, fwd_w, s1_word, enc_word, wb_word;
  logic              fwd_v;

  logic              s1_v, s1_host, s1_we, s1_fence, s1_last;
  logic [AW-1:0]     s1_addr;
  logic [DATA_W-1:0] s1_wdata;
  logic [WORD_W-1:0] s1_inj;

  logic [DATA_W-1:0] d_data, e_data;
  logic              d_comp, d_corr, d_unc, e_comp;
  logic              s1_rd, host_rd, wb_en, corr_evt;

  logic [WCW-1:0]    win_cnt;
  logic [ECW-1:0]    err_cnt;

  // issue stage: host first, walk takes idle slots
  assign walk_grant = walk_active && !req;
  assign issue_v    = req || walk_grant;
  assign issue_addr = req ? req_addr : walk_addr;

  kac_walker #(.DEPTH(DEPTH), .PERIOD(PERIOD)) u_walk (
    .clk(clk), .rst(rst), .grant(walk_grant),
    .active(walk_active), .addr(walk_addr), .last(walk_last)
  );

  // storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wb_en) mem[s1_addr] <= wb_word;
    rd_q <= mem[issue_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_host <= 1'b0; s1_we <= 1'b0; s1_fence <= 1'b0;
      s1_last <= 1'b0; s1_addr <= '0; s1_wdata <= '0; s1_inj <= '0;
      fwd_v <= 1'b0; fwd_w <= '0;
    end else begin
      s1_v     <= issue_v;
      s1_host  <= req;
      s1_we    <= req && req_we;
      s1_fence <= req && fault;
      s1_last  <= walk_grant && walk_last;
      s1_addr  <= issue_addr;
      s1_wdata <= req_wdata;
      s1_inj   <= req_inj;
      // write landing at this edge is not yet visible to the read port
      fwd_v    <= issue_v && wb_en && (s1_addr == issue_addr);
      fwd_w    <= wb_word;
    end
  end

  // second stage: decode, correct, re-encode
  assign s1_word = fwd_v ? fwd_w : rd_q;

  kac_ecc_dec u_dec (
    .word(s1_word), .apar(^s1_addr),
    .data(d_data), .comp(d_comp), .corr(d_corr), .unc(d_unc)
  );

  assign e_data = s1_we ? s1_wdata : ~d_data;
  assign e_comp = s1_we ? 1'b0 : ~d_comp;

  kac_ecc_enc u_enc (
    .data(e_data), .comp(e_comp), .apar(^s1_addr), .word(enc_word)
  );

  assign wb_word  = enc_word ^ (s1_we ? s1_inj : '0);
  assign s1_rd    = s1_v && !s1_fence && !s1_we;
  assign host_rd  = s1_rd && s1_host;
  assign wb_en    = s1_v && !s1_fence && (s1_we || (!s1_host && !d_unc));
  assign corr_evt = s1_rd && d_corr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      rsp_corr  <= 1'b0;
      pass_done <= 1'b0;
    end else begin
      rsp_valid <= s1_v && s1_host;
      rsp_err   <= s1_v && s1_host && (s1_fence || (host_rd && d_unc));
      rsp_corr  <= host_rd && d_corr;
      rsp_rdata <= (host_rd && !d_unc) ? (d_data ^ {DATA_W{d_comp}}) : '0;
      pass_done <= s1_v && !s1_host && s1_last;
    end
  end

  // corrected-error rate monitor
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      err_cnt <= '0;
      fault   <= 1'b0;
    end else begin
      if (win_cnt == WCW'(WINDOW - 1)) begin
        win_cnt <= '0;
        err_cnt <= ECW'(corr_evt);
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (corr_evt && (err_cnt <= ECW'(ERR_LIMIT))) err_cnt <= err_cnt + 1'b1;
      end
      if (corr_evt && (err_cnt >= ECW'(ERR_LIMIT))) fault <= 1'b1;
    end
  end
endmodule

// File: rtl/kac_chk.sv
module kac_chk
  import kac_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              fault,
  input logic              pass_done,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              rsp_corr,
  input logic [DATA_W-1:0] rsp_rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_RSP_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    req |-> ##2 rsp_valid); // R2
  AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req, 2)); // R2
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_err && !rsp_corr)); // R2
  AST_ERR_NOT_CORR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_err && rsp_corr)); // R4
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0)); // R4
  AST_PASS_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault); // R9
  AST_FENCE: assert property (@(posedge clk) disable iff (rst)
    (fault && req) |-> ##2 (rsp_valid && rsp_err)); // R10
endmodule

bind key_array_ctrl kac_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .fault(fault), .pass_done(pass_done),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_corr(rsp_corr),
  .rsp_rdata(rsp_rdata)
);

// File: tb/key_array_ctrl_tb.sv
module key_array_ctrl_tb;
  import kac_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 16;
  localparam int PERIOD = 3000;
  localparam int ERR_LIMIT = 8;
  localparam int WINDOW = 100000;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [WORD_W-1:0] req_inj = '0;
  logic rsp_valid, rsp_err, rsp_corr, fault, pass_done;
  logic [DATA_W-1:0] rsp_rdata;

  always #2.5 clk = ~clk;

  key_array_ctrl #(.DEPTH(DEPTH), .PERIOD(PERIOD), .ERR_LIMIT(ERR_LIMIT), .WINDOW(WINDOW)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_inj(req_inj), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_corr(rsp_corr),
    .fault(fault), .pass_done(pass_done)
  );

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              err;
    logic              corr;
    string             tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int fails = 0;
  int passes_seen = 0;
  int pass_cycle = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] pat(int a);
    return {32'hC0DE_0000 + 32'(a), 32'h5A5A_0F0F ^ 32'(a * 7)};
  endfunction

  function automatic logic [WORD_W-1:0] flip(int b);
    return WORD_W'(1) << b;
  endfunction

  task automatic expect_eq(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, drives one request cycle, queues expectation
  task automatic op(logic we, int a, logic [DATA_W-1:0] wd, logic [WORD_W-1:0] inj,
                    logic [DATA_W-1:0] ed, logic ee, logic ec, string tag);
    exp_t e;
    req = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = wd; req_inj = inj;
    e.data = ed; e.err = ee; e.corr = ec; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    req = 1'b0; req_we = 1'b0; req_inj = '0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && pass_done) begin
      passes_seen++;
      pass_cycle = cyc;
    end
    if (!rst && rsp_valid) begin
      if (sbq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: response with nothing outstanding got %h expected none", rsp_rdata);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (rsp_rdata !== e.data || rsp_err !== e.err || rsp_corr !== e.corr) begin
          fails++;
          $display("FAIL %s: got data %h err %b corr %b expected data %h err %b corr %b",
                   e.tag, rsp_rdata, rsp_err, rsp_corr, e.data, e.err, e.corr);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    expect_eq("R11 rsp_valid", 64'(rsp_valid), 0);
    expect_eq("R11 rsp_err", 64'(rsp_err), 0);
    expect_eq("R11 rsp_corr", 64'(rsp_corr), 0);
    expect_eq("R11 fault", 64'(fault), 0);
    expect_eq("R11 pass_done", 64'(pass_done), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: fill the array
    for (int a = 0; a < DEPTH; a++) op(1'b1, a, pat(a), '0, '0, 1'b0, 1'b0, "R1 write");
    op(1'b0, 0, '0, '0, pat(0), 1'b0, 1'b0, "R1 clean read");
    op(1'b0, 15, '0, '0, pat(15), 1'b0, 1'b0, "R1 clean read");
    // R2: read right behind write to same address
    op(1'b1, 8, pat(8), '0, '0, 1'b0, 1'b0, "R2 write");
    op(1'b0, 8, '0, '0, pat(8), 1'b0, 1'b0, "R2 read after write");
    // corrupt elements through the write mask
    op(1'b1, 3, pat(3), flip(5), '0, 1'b0, 1'b0, "R1 inj write");
    op(1'b1, 4, pat(4), flip(0) | flip(40), '0, 1'b0, 1'b0, "R1 inj write");
    op(1'b1, 5, pat(5), flip(66), '0, 1'b0, 1'b0, "R1 inj write");
    op(1'b1, 6, pat(6), flip(72), '0, 1'b0, 1'b0, "R1 inj write");
    op(1'b0, 3, '0, '0, pat(3), 1'b0, 1'b1, "R3 data bit");
    op(1'b0, 4, '0, '0, '0, 1'b1, 1'b0, "R4 double");
    op(1'b0, 5, '0, '0, pat(5), 1'b0, 1'b1, "R3 check bit");
    op(1'b0, 6, '0, '0, pat(6), 1'b0, 1'b1, "R5 indicator bit");
    drain();
    expect_eq("R9 no fault yet", 64'(fault), 0);

    // R8: keep the host busy across the walk on clean addresses
    for (int i = 0; i < 6000 && passes_seen == 0; i++) begin
      int idx;
      int a;
      idx = i % 12;
      a = (idx < 3) ? idx : idx + 4;
      if ((i % 3) == 2) @(negedge clk);
      else if ((i % 2) == 0) op(1'b0, a, '0, '0, pat(a), 1'b0, 1'b0, "R8 read in walk");
      else op(1'b1, a, pat(a), '0, '0, 1'b0, 1'b0, "R8 write in walk");
    end
    drain();
    expect_eq("R6 one pass done", 64'(passes_seen), 1);
    expect_eq("R6 pass not early", 64'(pass_cycle >= PERIOD), 1);

    // R6/R7: after the walk
    op(1'b0, 0, '0, '0, pat(0), 1'b0, 1'b0, "R6 true data after walk");
    op(1'b0, 15, '0, '0, pat(15), 1'b0, 1'b0, "R6 true data after walk");
    op(1'b0, 3, '0, '0, pat(3), 1'b0, 1'b0, "R7 scrubbed data bit");
    op(1'b0, 5, '0, '0, pat(5), 1'b0, 1'b0, "R7 scrubbed check bit");
    op(1'b0, 6, '0, '0, pat(6), 1'b0, 1'b0, "R7 scrubbed indicator");
    op(1'b0, 4, '0, '0, '0, 1'b1, 1'b0, "R7 double left alone");
    drain();
    expect_eq("R9 six events below limit", 64'(fault), 0);

    // R9: events 7, 8, 9
    op(1'b1, 7, pat(7), flip(10), '0, 1'b0, 1'b0, "R9 inj write");
    op(1'b0, 7, '0, '0, pat(7), 1'b0, 1'b1, "R9 event 7");
    op(1'b0, 7, '0, '0, pat(7), 1'b0, 1'b1, "R9 event 8");
    drain();
    expect_eq("R9 at limit no fault", 64'(fault), 0);
    op(1'b0, 7, '0, '0, pat(7), 1'b0, 1'b1, "R9 event 9");
    drain();
    expect_eq("R9 fault raised", 64'(fault), 1);

    // R10: fenced
    op(1'b0, 0, '0, '0, '0, 1'b1, 1'b0, "R10 fenced read");
    op(1'b1, 1, pat(1), '0, '0, 1'b1, 1'b0, "R10 fenced write");
    op(1'b0, 3, '0, '0, '0, 1'b1, 1'b0, "R10 fenced read");
    drain();
    repeat (20) @(negedge clk);
    expect_eq("R9 fault sticky", 64'(fault), 1);
    expect_eq("R2 scoreboard empty", 64'(sbq.size()), 0);
    finish_run();
  end
endmodule